// File: doc/BRIEF.md
# Quadrature Carrier Phase Generator with Per-Channel Sign Inversion

This block turns one clock running at twice the carrier frequency into two carrier-rate square waves spaced a quarter period apart: an in-phase clock and a quadrature clock. Both have a 50% duty cycle. The in-phase divider stage toggles on every rising edge of the input clock. The quadrature stage copies the in-phase stage on every falling edge, so it trails by half an input period, which is 90 degrees of the carrier.

Each phase has its own sign bit. When the sign bit is set, the phase is inverted. The captured sign pair therefore selects the quadrant of the complex plane in which the summed capacitor-array output lands:

| In-phase sign | Quadrature sign | Quadrant |
|---|---|---|
| 0 | 0 | I |
| 1 | 0 | II |
| 1 | 1 | III |
| 0 | 1 | IV |

A sign bit is taken into its channel only on an edge where the unsigned phase of that channel is low. A change of sign therefore can never produce a pulse shorter than half a carrier period. The outputs drive the switch drivers of the capacitor cells.

Top module: `qclk_gen`

## Requirements
- R1: While `rst_ni` is low, asynchronously and without waiting for a clock edge, both `i_clk_o` and `q_clk_o` are 0 and both captured sign bits are cleared.
- R2: With the captured in-phase sign at 0, `i_clk_o` toggles on every rising edge of `clk2x_i`. This gives a 50% duty square wave with a period of two input cycles.
- R3: The unsigned quadrature phase equals the unsigned in-phase value taken at each falling edge of `clk2x_i`. The quadrature clock therefore rises half an input period (a quarter carrier period) after the in-phase clock rises.
- R4: With the captured quadrature sign at 0, `q_clk_o` is a 50% duty square wave with a period of two input cycles.
- R5: `i_clk_o` is the unsigned in-phase clock XOR the captured in-phase sign. A sign value of 1 inverts the phase.
- R6: `i_sign_i` is captured only at a rising edge where the unsigned in-phase clock is low before the edge. At every other rising edge it is ignored and the captured value holds.
- R7: `q_sign_i` is captured only at a falling edge where the unsigned quadrature clock is low before the edge. At every other falling edge it is ignored.
- R8: `q_clk_o` is the unsigned quadrature clock XOR the captured quadrature sign, independently of the in-phase sign. All four sign pairs are supported; (I,Q) = (1,0) gives quadrant II, (1,1) quadrant III and (0,1) quadrant IV.
- R9: After reset is released while `clk2x_i` is low, the first output change is `i_clk_o` going high at the first rising edge. `q_clk_o` follows at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 1 | Clock at twice the carrier frequency |
| rst_ni | input | 1 | Asynchronous active-low reset |
| i_sign_i | input | 1 | In-phase sign, 1 = invert |
| q_sign_i | input | 1 | Quadrature sign, 1 = invert |
| i_clk_o | output | 1 | Signed in-phase carrier clock |
| q_clk_o | output | 1 | Signed quadrature carrier clock |

## Verification
The in-phase result and its sign capture are due at the rising edge of `clk2x_i`. The quadrature result and its sign capture are due at the falling edge. In both cases the output follows the edge with no further register stage.

The bench samples both outputs a quarter input period after every edge of either polarity. It changes the sign inputs a short delay after a rising edge. A sign change therefore reaches an output only at the next edge of its own channel where that channel's phase is low.

The reference model keeps an edge count and the captured signs. Checks made while a sign change is still pending are labelled as checks of the ignore rule.

// File: rtl/qclk_pkg.sv
package qclk_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;

  localparam int NUM_CH = 2;
  localparam int CH_I   = 0;
  localparam int CH_Q   = 1;
endpackage

// File: rtl/qclk_divider.sv
module qclk_divider (
  input  logic clk_i,
  input  logic rst_ni,
  output logic i_raw_o,
  output logic q_raw_o
);
  logic i_q, q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) i_q <= 1'b0;
    else         i_q <= ~i_q;
  end

  // quadrature stage trails by half an input period
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= i_q;
  end

  assign i_raw_o = i_q;
  assign q_raw_o = q_q;

  // R3: just before each rising edge Q has caught up with I
  assert_q_tracks_i_R3: assert property (
    @(posedge clk_i) disable iff (!rst_ni) q_q == i_q
  );
endmodule

// File: rtl/qclk_sign.sv
module qclk_sign
  import qclk_pkg::*;
#(
  parameter edge_e EDGE = EDGE_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phase_i,
  input  logic sign_i,
  output logic phase_o
);
  logic sgn_q;

  if (EDGE == EDGE_RISE) begin : g_rise
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sgn_q <= 1'b0;
      else if (!phase_i) sgn_q <= sign_i;
    end

    assert_sign_hold_R6: assert property (
      @(posedge clk_i) disable iff (!rst_ni) phase_i |=> sgn_q == $past(sgn_q)
    );
    assert_sign_take_R6: assert property (
      @(posedge clk_i) disable iff (!rst_ni) !phase_i |=> sgn_q == $past(sign_i)
    );
  end else begin : g_fall
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sgn_q <= 1'b0;
      else if (!phase_i) sgn_q <= sign_i;
    end

    assert_sign_hold_R7: assert property (
      @(negedge clk_i) disable iff (!rst_ni) phase_i |=> sgn_q == $past(sgn_q)
    );
    assert_sign_take_R7: assert property (
      @(negedge clk_i) disable iff (!rst_ni) !phase_i |=> sgn_q == $past(sign_i)
    );
  end

  assign phase_o = phase_i ^ sgn_q;
endmodule

// File: rtl/qclk_gen.sv
module qclk_gen
  import qclk_pkg::*;
(
  input  logic clk2x_i,
  input  logic rst_ni,
  input  logic i_sign_i,
  input  logic q_sign_i,
  output logic i_clk_o,
  output logic q_clk_o
);
  logic [NUM_CH-1:0] raw;
  logic [NUM_CH-1:0] sgn_in;
  logic [NUM_CH-1:0] ph_out;

  qclk_divider u_div (
    .clk_i   (clk2x_i),
    .rst_ni  (rst_ni),
    .i_raw_o (raw[CH_I]),
    .q_raw_o (raw[CH_Q])
  );

  assign sgn_in[CH_I] = i_sign_i;
  assign sgn_in[CH_Q] = q_sign_i;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam edge_e CH_EDGE = (ch == CH_I) ? EDGE_RISE : EDGE_FALL;
    qclk_sign #(.EDGE(CH_EDGE)) u_sign (
      .clk_i   (clk2x_i),
      .rst_ni  (rst_ni),
      .phase_i (raw[ch]),
      .sign_i  (sgn_in[ch]),
      .phase_o (ph_out[ch])
    );
  end

  assign i_clk_o = ph_out[CH_I];
  assign q_clk_o = ph_out[CH_Q];

  assert_reset_low_R1: assert property (
    @(posedge clk2x_i) !rst_ni |-> (!i_clk_o && !q_clk_o)
  );
endmodule

// File: tb/test_qclk_gen.sv
module test_qclk_gen;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic i_sign = 1'b0;
  logic q_sign = 1'b0;
  logic i_clk, q_clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  qclk_gen i_qclk_gen (
    .clk2x_i  (clk),
    .rst_ni   (rst_ni),
    .i_sign_i (i_sign),
    .q_sign_i (q_sign),
    .i_clk_o  (i_clk),
    .q_clk_o  (q_clk)
  );

  always #4 clk = ~clk;  // 125 MHz

  // reference model: rising-edge count sets the I level, Q follows I at falling edges
  int rises;
  bit m_i, m_q, m_isg, m_qsg;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rises = 0; m_i = 0; m_q = 0; m_isg = 0; m_qsg = 0;
    end else begin
      if (rises % 2 == 0) m_isg = i_sign;
      rises++;
      m_i = (rises % 2) == 1;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      if (!m_q) m_qsg = q_sign;
      m_q = m_i;
    end
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic sample();
    string ti, tq;
    if (!rst_ni) begin
      ti = "R1"; tq = "R1";
    end else begin
      ti = (m_isg != i_sign) ? "R6" : (m_isg ? "R5" : "R2");
      tq = (m_qsg != q_sign) ? "R7" : (m_qsg ? "R8" : "R4");
    end
    chk(ti, int'(i_clk), int'(m_i ^ m_isg), "i_clk_o");
    chk(tq, int'(q_clk), int'(m_q ^ m_qsg), "q_clk_o");
  endtask

  always @(posedge clk) begin #2; if (!done) sample(); end
  always @(negedge clk) begin #2; if (!done) sample(); end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    int hi_i, hi_q;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk("R1", int'(i_clk), 0, "i_clk_o in reset");
    chk("R1", int'(q_clk), 0, "q_clk_o in reset");
    rst_ni = 1'b1;

    // R9 / R3: ordering after reset release
    @(posedge clk); #2;
    chk("R9", int'(i_clk), 1, "I high at first rising edge");
    chk("R9", int'(q_clk), 0, "Q still low");
    @(negedge clk); #2;
    chk("R3", int'(q_clk), 1, "Q high half cycle later");
    chk("R3", int'(i_clk), 1, "I still high");
    @(posedge clk); #2;
    chk("R3", int'(i_clk), 0, "I falls");
    chk("R3", int'(q_clk), 1, "Q still high");
    @(negedge clk); #2;
    chk("R3", int'(q_clk), 0, "Q falls");

    // R2 / R4: duty over 8 carrier quarter-samples pairs
    hi_i = 0; hi_q = 0;
    for (int n = 0; n < 8; n++) begin
      @(posedge clk); #2; hi_i += int'(i_clk); hi_q += int'(q_clk);
      @(negedge clk); #2; hi_i += int'(i_clk); hi_q += int'(q_clk);
    end
    chk("R2", hi_i, 8, "I high samples of 16");
    chk("R4", hi_q, 8, "Q high samples of 16");

    // R5 / R8: every sign pair
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); #1;
      i_sign = c[0];
      q_sign = c[1];
      repeat (6) @(posedge clk);
    end

    // R6 / R7: sign changes at arbitrary times
    repeat (300) begin
      @(posedge clk); #1;
      if ($urandom_range(0, 3) == 0) i_sign = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) q_sign = 1'($urandom_range(0, 1));
    end

    // R1: reset in mid-run with both signs set
    @(posedge clk); #1; i_sign = 1'b1; q_sign = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_ni = 1'b0;
    @(negedge clk); #2;
    chk("R1", int'(i_clk), 0, "i_clk_o after mid-run reset");
    chk("R1", int'(q_clk), 0, "q_clk_o after mid-run reset");
    @(negedge clk); #1 rst_ni = 1'b1;
    repeat (20) @(posedge clk);

    #3 done = 1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule